// File: doc/BRIEF.md
# Burst Memory Address Controller

This block sits in front of a synchronous memory array and decides, on every rising clock edge, where the next access goes. Two active-low address strobes can start a new access: one driven by a host processor and one by a memory controller. Three chip enables decide whether a newly started access selects the device. The block registers the upper address bits and runs a small burst counter over the low bits. An active-low step input then walks through a four-word block without any new address from outside.

The burst order comes from a static strap input. Linear order counts upward and wraps. Interleaved order flips the low bits by XOR with the step count. The block has three registered outputs: the effective memory address, a device-selected flag and a cycle-kind code. The array behind it uses these to know what kind of access is under way. There is no data path, so all pins are plain control and status signals. No valid/ready handshake applies and no back-pressure exists. All outputs change one clock edge after the inputs that cause them.

Top module: `burst_addr_ctl`

## Requirements
- R1: A load happens on a rising edge where either `strobe_host_n` is low with `en_a_n` low, or `strobe_ctl_n` is low. After that edge `mem_addr` equals the `addr_in` sampled at that edge.
- R2: When both strobes are low and `en_a_n` is low, the load is credited to the host strobe. On a selecting load `cyc_kind` reads 1 for a host load and 2 for a controller load.
- R3: When `en_a_n` is high, `strobe_host_n` has no effect. With `strobe_ctl_n` high the address and `dev_sel` keep their values. With `strobe_ctl_n` low the controller load takes place.
- R4: `dev_sel` is set to (`en_a_n`==0 and `en_b`==1 and `en_c_n`==0) only on a load edge. Chip enable levels on other edges are ignored.
- R5: After a load with the enables inactive, `dev_sel` is 0 and `cyc_kind` is 0 (idle). This holds until a selecting load. While deselected, `step_n` leaves `mem_addr` unchanged.
- R6: On every load the burst counter is seeded with `addr_in[1:0]`. `mem_addr` is the registered upper bits concatenated with the current burst low bits.
- R7: On a non-load edge while selected, `step_n` low advances the burst by exactly one and gives `cyc_kind` 3. `step_n` high keeps `mem_addr` and gives `cyc_kind` 4.
- R8: With `order_il`=0 (linear) the low bits are (seed + steps) mod 4.
- R9: With `order_il`=1 (interleaved, the level to tie for the default order) the low bits are seed XOR steps. A seed of 1 therefore gives 1,0,3,2.
- R10: The burst wraps inside its four-word block. The upper bits of `mem_addr` never change except on a load.
- R11: `step_n` has no effect on a load edge. The low bits after a load always equal the seed.
- R12: While reset is held, `mem_addr` is 0, `dev_sel` is 0 and `cyc_kind` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe_host_n | input | 1 | Host address strobe, active low |
| strobe_ctl_n | input | 1 | Controller address strobe, active low |
| en_a_n | input | 1 | Chip enable A, active low; also gates the host strobe |
| en_b | input | 1 | Chip enable B, active high |
| en_c_n | input | 1 | Chip enable C, active low |
| step_n | input | 1 | Burst advance, active low |
| order_il | input | 1 | Static burst order: 0 linear, 1 interleaved |
| addr_in | input | AW (18) | External address |
| mem_addr | output | AW (18) | Effective memory address |
| dev_sel | output | 1 | Device selected by the last load |
| cyc_kind | output | 3 | 0 idle, 1 host load, 2 controller load, 3 burst step, 4 hold |

## Verification
The hardest case to reach is the one where both strobes are low while enable A is high. Here the host strobe must drop out and the controller strobe must still load, and that load then deselects the device. The bench gets there by first building a selected burst with a known address. It then drives the double strobe with a different address and checks three things: the new address was taken, the device is now deselected, and later step pulses leave the address frozen. A separate scenario changes every chip enable in the middle of a burst to show they are ignored until the next load.

// File: rtl/bac_pkg.sv
package bac_pkg;
  typedef enum logic [2:0] {
    CYC_IDLE  = 3'd0,
    CYC_HOST  = 3'd1,
    CYC_CTL   = 3'd2,
    CYC_BURST = 3'd3,
    CYC_HOLD  = 3'd4
  } cyc_kind_e;
endpackage

// File: rtl/bac_strobe_decode.sv
module bac_strobe_decode (
  input  logic strobe_host_n,
  input  logic strobe_ctl_n,
  input  logic en_a_n,
  input  logic en_b,
  input  logic en_c_n,
  output logic load,
  output logic by_host,
  output logic ce_ok
);
  logic host_take;
  logic ctl_take;

  // host strobe only counts when enable A is active; it wins over the controller
  assign host_take = !strobe_host_n && !en_a_n;
  assign ctl_take  = !strobe_ctl_n && !host_take;
  assign load      = host_take || ctl_take;
  assign by_host   = host_take;
  assign ce_ok     = !en_a_n && en_b && !en_c_n;
endmodule

// File: rtl/bac_burst_ctr.sv
module bac_burst_ctr #(
  parameter int BW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [BW-1:0] seed,
  input  logic          step_en,
  input  logic          order_il,
  output logic [BW-1:0] low_o
);
  logic [BW-1:0] start_q;
  logic [BW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= '0;
      cnt_q   <= '0;
    end else if (load) begin
      start_q <= seed;
      cnt_q   <= '0;
    end else if (step_en) begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  // sum is truncated to BW bits, so the burst wraps inside its block
  always_comb begin
    if (order_il) low_o = start_q ^ cnt_q;
    else          low_o = start_q + cnt_q;
  end
endmodule

// File: rtl/bac_addr_reg.sv
module bac_addr_reg
  import bac_pkg::*;
#(
  parameter int AW = 18,
  parameter int BW = 2,
  localparam int UW = AW - BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          by_host,
  input  logic          ce_ok,
  input  logic          step_req,
  input  logic [UW-1:0] upper_in,
  output logic          step_en,
  output logic [UW-1:0] upper_o,
  output logic          sel_o,
  output cyc_kind_e     cyc_o
);
  logic [UW-1:0] upper_q;
  logic          sel_q;
  cyc_kind_e     cyc_q;
  cyc_kind_e     cyc_d;

  assign step_en = !load && sel_q && step_req;

  always_comb begin
    if (load) begin
      if (!ce_ok)      cyc_d = CYC_IDLE;
      else if (by_host) cyc_d = CYC_HOST;
      else             cyc_d = CYC_CTL;
    end else if (!sel_q) begin
      cyc_d = CYC_IDLE;
    end else if (step_req) begin
      cyc_d = CYC_BURST;
    end else begin
      cyc_d = CYC_HOLD;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upper_q <= '0;
      sel_q   <= 1'b0;
      cyc_q   <= CYC_IDLE;
    end else begin
      cyc_q <= cyc_d;
      if (load) begin
        upper_q <= upper_in;
        sel_q   <= ce_ok;
      end
    end
  end

  assign upper_o = upper_q;
  assign sel_o   = sel_q;
  assign cyc_o   = cyc_q;
endmodule

// File: rtl/burst_addr_ctl.sv
module burst_addr_ctl
  import bac_pkg::*;
#(
  parameter int AW = 18,
  parameter int BW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe_host_n,
  input  logic          strobe_ctl_n,
  input  logic          en_a_n,
  input  logic          en_b,
  input  logic          en_c_n,
  input  logic          step_n,
  input  logic          order_il,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] mem_addr,
  output logic          dev_sel,
  output logic [2:0]    cyc_kind
);
  localparam int UW = AW - BW;

  logic          load;
  logic          by_host;
  logic          ce_ok;
  logic          step_en;
  logic [UW-1:0] upper;
  logic [BW-1:0] low;
  cyc_kind_e     cyc;

  bac_strobe_decode u_dec (
    .strobe_host_n (strobe_host_n),
    .strobe_ctl_n  (strobe_ctl_n),
    .en_a_n        (en_a_n),
    .en_b          (en_b),
    .en_c_n        (en_c_n),
    .load          (load),
    .by_host       (by_host),
    .ce_ok         (ce_ok)
  );

  bac_addr_reg #(.AW(AW), .BW(BW)) u_areg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .by_host  (by_host),
    .ce_ok    (ce_ok),
    .step_req (!step_n),
    .upper_in (addr_in[AW-1:BW]),
    .step_en  (step_en),
    .upper_o  (upper),
    .sel_o    (dev_sel),
    .cyc_o    (cyc)
  );

  bac_burst_ctr #(.BW(BW)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .seed     (addr_in[BW-1:0]),
    .step_en  (step_en),
    .order_il (order_il),
    .low_o    (low)
  );

  assign mem_addr = {upper, low};
  assign cyc_kind = cyc;
endmodule

// File: rtl/burst_addr_ctl_chk.sv
module burst_addr_ctl_chk #(
  parameter int AW = 18,
  parameter int BW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          strobe_host_n,
  input logic          strobe_ctl_n,
  input logic          en_a_n,
  input logic          en_b,
  input logic          en_c_n,
  input logic [AW-1:0] addr_in,
  input logic [AW-1:0] mem_addr,
  input logic          dev_sel,
  input logic [2:0]    cyc_kind
);
  logic load_seen;
  assign load_seen = (!strobe_host_n && !en_a_n) || !strobe_ctl_n;

  // R1
  load_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_seen |=> mem_addr == $past(addr_in));

  // R2
  host_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_host_n && !strobe_ctl_n && !en_a_n && en_b && !en_c_n) |=> cyc_kind == 3'd1);

  // R3
  host_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_host_n && en_a_n && strobe_ctl_n) |=> $stable(dev_sel) && $stable(mem_addr[AW-1:BW]));

  // R4
  sel_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_seen |=> dev_sel == $past(!en_a_n && en_b && !en_c_n));

  // R5
  desel_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dev_sel && !load_seen) |=> !dev_sel && $stable(mem_addr) && cyc_kind == 3'd0);

  // R10
  upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_seen |=> $stable(mem_addr[AW-1:BW]));
endmodule

bind burst_addr_ctl burst_addr_ctl_chk #(.AW(AW), .BW(BW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .strobe_host_n (strobe_host_n),
  .strobe_ctl_n  (strobe_ctl_n),
  .en_a_n        (en_a_n),
  .en_b          (en_b),
  .en_c_n        (en_c_n),
  .addr_in       (addr_in),
  .mem_addr      (mem_addr),
  .dev_sel       (dev_sel),
  .cyc_kind      (cyc_kind)
);

// File: tb/burst_addr_ctl_tb_top.sv
module burst_addr_ctl_tb_top;
  localparam int AW = 18;
  localparam logic [2:0] K_IDLE = 3'd0, K_HOST = 3'd1, K_CTL = 3'd2,
                         K_BURST = 3'd3, K_HOLD = 3'd4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strobe_host_n = 1'b1, strobe_ctl_n = 1'b1;
  logic en_a_n = 1'b0, en_b = 1'b1, en_c_n = 1'b0;
  logic step_n = 1'b1, order_il = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] mem_addr;
  logic dev_sel;
  logic [2:0] cyc_kind;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  burst_addr_ctl #(.AW(AW), .BW(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .strobe_host_n(strobe_host_n),
    .strobe_ctl_n(strobe_ctl_n), .en_a_n(en_a_n), .en_b(en_b),
    .en_c_n(en_c_n), .step_n(step_n), .order_il(order_il),
    .addr_in(addr_in), .mem_addr(mem_addr), .dev_sel(dev_sel),
    .cyc_kind(cyc_kind)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic drive(input logic hn, input logic cn, input logic a, input logic b,
                       input logic c, input logic st, input logic [AW-1:0] ad);
    strobe_host_n = hn; strobe_ctl_n = cn; en_a_n = a; en_b = b; en_c_n = c;
    step_n = st; addr_in = ad;
    tick();
  endtask

  task automatic idle_step(input logic st);
    drive(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, st, 18'h3FFFF);
  endtask

  task automatic chk(input string req, input logic [AW-1:0] ea, input logic es,
                     input logic [2:0] ek);
    total++;
    if (mem_addr !== ea || dev_sel !== es || cyc_kind !== ek) begin
      bad++;
      $display("FAIL %s: addr=%h sel=%b kind=%0d expected addr=%h sel=%b kind=%0d",
               req, mem_addr, dev_sel, cyc_kind, ea, es, ek);
    end
  endtask

  task automatic t_reset();
    chk("R12", 18'h0, 1'b0, K_IDLE);
    rst_n = 1'b1;
  endtask

  task automatic t_linear();
    order_il = 1'b0;
    drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 18'h2A5C5);
    chk("R1 R6 host load", 18'h2A5C5, 1'b1, K_HOST);
    idle_step(1'b0); chk("R8 R7 linear step1", 18'h2A5C6, 1'b1, K_BURST);
    idle_step(1'b0); chk("R8 linear step2", 18'h2A5C7, 1'b1, K_BURST);
    idle_step(1'b0); chk("R10 linear wrap", 18'h2A5C4, 1'b1, K_BURST);
    idle_step(1'b1); chk("R7 hold", 18'h2A5C4, 1'b1, K_HOLD);
  endtask

  task automatic t_interleave();
    order_il = 1'b1;
    drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 18'h00011);
    chk("R1 R2 ctl load", 18'h00011, 1'b1, K_CTL);
    idle_step(1'b0); chk("R9 il step1", 18'h00010, 1'b1, K_BURST);
    idle_step(1'b0); chk("R9 il step2", 18'h00013, 1'b1, K_BURST);
    idle_step(1'b0); chk("R9 il step3", 18'h00012, 1'b1, K_BURST);
    idle_step(1'b0); chk("R10 il wrap", 18'h00011, 1'b1, K_BURST);
  endtask

  task automatic t_priority();
    drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 18'h1F00E);
    chk("R2 both strobes", 18'h1F00E, 1'b1, K_HOST);
  endtask

  task automatic t_host_masked();
    order_il = 1'b0;
    drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 18'h05550);
    drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 18'h3AAAB);
    chk("R3 host ignored", 18'h05550, 1'b1, K_HOLD);
    drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 18'h3AAAB);
    chk("R3 ctl takes over deselect", 18'h3AAAB, 1'b0, K_IDLE);
    idle_step(1'b0); chk("R5 step ignored deselected", 18'h3AAAB, 1'b0, K_IDLE);
    idle_step(1'b0); chk("R5 still deselected", 18'h3AAAB, 1'b0, K_IDLE);
    drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 18'h00102);
    chk("R5 reselect", 18'h00102, 1'b1, K_CTL);
  endtask

  task automatic t_enables();
    order_il = 1'b0;
    drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 18'h12340);
    drive(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 18'h0);
    chk("R4 enables ignored mid burst", 18'h12341, 1'b1, K_BURST);
    drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 18'h00200);
    chk("R4 en_b low deselects", 18'h00200, 1'b0, K_IDLE);
    drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 18'h00300);
    chk("R4 en_c high deselects", 18'h00300, 1'b0, K_IDLE);
  endtask

  task automatic t_step_on_load();
    order_il = 1'b1;
    drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 18'h00400);
    idle_step(1'b0);
    drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 18'h0ABC2);
    chk("R11 step ignored on load", 18'h0ABC2, 1'b1, K_HOST);
    idle_step(1'b0); chk("R11 R9 step after load", 18'h0ABC3, 1'b1, K_BURST);
  endtask

  initial begin
    tick(); tick();
    t_reset();
    t_linear();
    t_interleave();
    t_priority();
    t_host_masked();
    t_enables();
    t_step_on_load();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule